// File: doc/BRIEF.md
# Return-Address Stack with Single-Level Context Shadow

This block keeps the return addresses of nested subroutine calls and interrupt entries in dedicated storage, separate from data memory. A call strobes `push_i` with the address to resume at, which the caller has already formed: the PC plus four for the two-word absolute call, or the PC plus two for the relative call. A return strobes `pop_i`. In that cycle `tos_o` carries the address that becomes the next PC, and the pointer drops one entry at the following clock edge. The default storage is 31 entries of 21 bits, and a 5-bit pointer counts the occupied entries. A pointer value of zero means the stack is empty.

A fast bit travels with each strobe. On a push it copies the working register, the status register and the bank register into a one-level shadow. On a pop it raises `restore_o`, which tells the core to load the shadow contents shown on the `*_o` outputs back into those three registers. Pushing onto a full stack and popping an empty one set sticky error flags, and each of those operations leaves the stored contents untouched.

Top module: `ret_stack`

## Requirements
- R1: After reset the pointer is 0, `tos_o` is 0, both error flags are 0 and all three shadow outputs are 0.
- R2: A push with the pointer below DEPTH raises the pointer by one and stores `ret_addr_i`. From the next cycle on, `tos_o` shows that address.
- R3: In the cycle `pop_i` is high, `tos_o` holds the most recently pushed entry that has not yet been popped. After the edge, the pointer is one lower and `tos_o` shows the entry below it, so entries come out in last-in, first-out order.
- R4: The stack holds exactly DEPTH (31) addresses. DEPTH pushes from empty bring the pointer to 31 and set no flag.
- R5: A push while the pointer equals DEPTH sets `ovf_o`. It stores nothing, and both the pointer and `tos_o` stay as they were.
- R6: A pop while the pointer is 0 sets `unf_o`, presents 0 on `tos_o` and leaves the pointer at 0.
- R7: `ovf_o` and `unf_o` stay set until reset, even when later operations are legal.
- R8: When `push_i` and `pop_i` are both high, the push takes place and the pop is ignored: the pointer rises by one, the new address is on top, and `restore_o` stays 0.
- R9: A push with `fast_i`=1 copies `w_i`, `status_i` and `bank_i` into the shadow, which appears on `w_o`, `status_o` and `bank_o` from the next cycle. A push with `fast_i`=0 leaves the shadow unchanged.
- R10: The shadow has one level, so each fast push overwrites the values saved before.
- R11: `restore_o` is 1 in exactly those cycles where `pop_i`=1, `fast_i`=1 and `push_i`=0. A pop with `fast_i`=0 keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call strobe |
| pop_i | input | 1 | Return strobe |
| fast_i | input | 1 | Save the context on a push, restore it on a pop |
| ret_addr_i | input | 21 | Return address to store |
| w_i | input | 8 | Working register value to shadow |
| status_i | input | 8 | Status register value to shadow |
| bank_i | input | 4 | Bank register value to shadow |
| tos_o | output | 21 | Top entry, which is the next PC on a return (0 when empty) |
| ptr_o | output | 5 | Number of stored entries |
| w_o | output | 8 | Shadowed working register |
| status_o | output | 8 | Shadowed status register |
| bank_o | output | 4 | Shadowed bank register |
| restore_o | output | 1 | Fast return: load the shadow outputs back |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The bench fills the stack to exactly 31 entries and then pushes once more. A design with an off-by-one full test would either drop the 31st address or overwrite the top entry, and the pops that follow would return the wrong sequence. It pops an empty stack to expose a pointer that wraps to 31 or a top value that is not zero. It asserts push and pop together to catch a design that lets the pop take part. It also alternates fast and plain pushes so that a shadow which saves on every push, or one that fails to take the newest values, shows stale data.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

   typedef enum logic [2:0] {
      OPK_NONE   = 3'd0,
      OPK_PUSH   = 3'd1,
      OPK_POP    = 3'd2,
      OPK_PUSH_X = 3'd3,
      OPK_POP_X  = 3'd4
   } stk_op_e;

   function automatic stk_op_e stk_decode(input logic push, input logic pop,
                                          input logic full, input logic empty);
      if (push)
         return full ? OPK_PUSH_X : OPK_PUSH;
      else if (pop)
         return empty ? OPK_POP_X : OPK_POP;
      else
         return OPK_NONE;
   endfunction

endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
   import ret_stack_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int PTR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] ptr,
   output stk_op_e          op,
   output logic             ovf,
   output logic             unf
);
   localparam logic [PTR_W-1:0] FULL_V = PTR_W'(DEPTH);

   logic full, empty;

   assign full  = (ptr == FULL_V);
   assign empty = (ptr == '0);
   assign op    = stk_decode(push, pop, full, empty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         unique case (op)
            OPK_PUSH:   ptr <= ptr + 1'b1;
            OPK_POP:    ptr <= ptr - 1'b1;
            OPK_PUSH_X: ovf <= 1'b1;
            OPK_POP_X:  unf <= 1'b1;
            default:    ;
         endcase
      end
   end

   assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && ptr != FULL_V) |=> ptr == $past(ptr) + 1'b1);
   assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && ptr != '0) |=> ptr == $past(ptr) - 1'b1);
   assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= FULL_V);
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && ptr == FULL_V) |=> ovf && $stable(ptr));
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && ptr == '0) |=> unf && ptr == '0);
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
   parameter int DEPTH = 31,
   parameter int PTR_W = 5,
   parameter int AW    = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [AW-1:0]    wr_data,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [AW-1:0]    rd_data
);
   localparam int SLOTS = 2 ** PTR_W;

   logic [AW-1:0] slot [SLOTS];

   assign slot[0] = '0;

   for (genvar i = 1; i < SLOTS; i++) begin : g_slot
      if (i <= DEPTH) begin : g_live
         logic [AW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_idx == PTR_W'(i))
               q <= wr_data;
         end
         assign slot[i] = q;
      end else begin : g_dead
         assign slot[i] = '0;
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ret_stack_shadow.sv
module ret_stack_shadow #(
   parameter int W_W = 8,
   parameter int S_W = 8,
   parameter int B_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           save,
   input  logic [W_W-1:0] w_in,
   input  logic [S_W-1:0] s_in,
   input  logic [B_W-1:0] b_in,
   output logic [W_W-1:0] w_out,
   output logic [S_W-1:0] s_out,
   output logic [B_W-1:0] b_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_out <= '0;
         s_out <= '0;
         b_out <= '0;
      end else if (save) begin
         w_out <= w_in;
         s_out <= s_in;
         b_out <= b_in;
      end
   end

   assert_shadow_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      save |=> (w_out == $past(w_in) && s_out == $past(s_in) && b_out == $past(b_in)));
   assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !save |=> ($stable(w_out) && $stable(s_out) && $stable(b_out)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
   import ret_stack_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   parameter int W_W   = 8,
   parameter int S_W   = 8,
   parameter int B_W   = 4,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             fast_i,
   input  logic [AW-1:0]    ret_addr_i,
   input  logic [W_W-1:0]   w_i,
   input  logic [S_W-1:0]   status_i,
   input  logic [B_W-1:0]   bank_i,
   output logic [AW-1:0]    tos_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic [W_W-1:0]   w_o,
   output logic [S_W-1:0]   status_o,
   output logic [B_W-1:0]   bank_o,
   output logic             restore_o,
   output logic             ovf_o,
   output logic             unf_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("ret_stack: DEPTH must be at least 1");
   end
   if (AW < 1 || W_W < 1 || S_W < 1 || B_W < 1) begin : g_bad_width
      $error("ret_stack: widths must be positive");
   end

   stk_op_e          op;
   logic [PTR_W-1:0] wr_idx;

   ret_stack_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push_i),
      .pop  (pop_i),
      .ptr  (ptr_o),
      .op   (op),
      .ovf  (ovf_o),
      .unf  (unf_o)
   );

   assign wr_idx = ptr_o + 1'b1;

   ret_stack_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .AW(AW)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (op == OPK_PUSH),
      .wr_idx (wr_idx),
      .wr_data(ret_addr_i),
      .rd_idx (ptr_o),
      .rd_data(tos_o)
   );

   ret_stack_shadow #(.W_W(W_W), .S_W(S_W), .B_W(B_W)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .save (push_i && fast_i),
      .w_in (w_i),
      .s_in (status_i),
      .b_in (bank_i),
      .w_out(w_o),
      .s_out(status_o),
      .b_out(bank_o)
   );

   assign restore_o = pop_i && fast_i && !push_i;

   assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && ptr_o != PTR_W'(DEPTH)) |=> tos_o == $past(ret_addr_i));
   assert_top_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && ptr_o == PTR_W'(DEPTH)) |=> $stable(tos_o));
   assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_o == '0 |-> tos_o == '0);
endmodule

// File: tb/ret_stack_tb.sv
module ret_stack_tb;
   localparam int CLK_NS = 10;
   localparam int DEPTH  = 31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 1'b0, pop_i = 1'b0, fast_i = 1'b0;
   logic [20:0] ret_addr_i = '0;
   logic [7:0]  w_i = '0, status_i = '0;
   logic [3:0]  bank_i = '0;
   logic [20:0] tos_o;
   logic [4:0]  ptr_o;
   logic [7:0]  w_o, status_o;
   logic [3:0]  bank_o;
   logic        restore_o, ovf_o, unf_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [20:0] mdl[$];
   logic [20:0] exp_tos_q[$];
   logic        exp_rst_q[$];

   always #(CLK_NS/2) clk = ~clk;

   ret_stack u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .fast_i(fast_i),
      .ret_addr_i(ret_addr_i), .w_i(w_i), .status_i(status_i), .bank_i(bank_i),
      .tos_o(tos_o), .ptr_o(ptr_o), .w_o(w_o), .status_o(status_o), .bank_o(bank_o),
      .restore_o(restore_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // driver: applies one operation and queues what the monitor must see
   task automatic op(input bit pu, input bit po, input bit fa, input logic [20:0] a,
                     input logic [7:0] w, input logic [7:0] s, input logic [3:0] b);
      @(posedge clk); #1;
      push_i = pu; pop_i = po; fast_i = fa;
      ret_addr_i = a; w_i = w; status_i = s; bank_i = b;
      if (pu) begin
         if (mdl.size() < DEPTH) mdl.push_back(a);
      end else if (po) begin
         exp_tos_q.push_back(mdl.size() == 0 ? 21'd0 : mdl[$]);
         exp_rst_q.push_back(fa);
         if (mdl.size() != 0) void'(mdl.pop_back());
      end
   endtask

   task automatic idle();
      @(posedge clk); #1;
      push_i = 0; pop_i = 0; fast_i = 0;
   endtask

   // monitor: compares the popped address and the restore strobe
   always @(negedge clk) begin
      if (rst_n && pop_i) begin
         if (push_i) begin
            chk("R8 restore during push+pop", {31'd0, restore_o}, 32'd0);
         end else if (exp_tos_q.size() == 0) begin
            chk("R3 unexpected pop", 32'd1, 32'd0);
         end else begin
            chk("R3 popped address", {11'd0, tos_o}, {11'd0, exp_tos_q.pop_front()});
            chk("R11 restore strobe", {31'd0, restore_o}, {31'd0, exp_rst_q.pop_front()});
         end
      end
   end

   initial begin
      #(CLK_NS * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1
      chk("R1 ptr", ptr_o, 0);
      chk("R1 tos", tos_o, 0);
      chk("R1 ovf", ovf_o, 0);
      chk("R1 unf", unf_o, 0);
      chk("R1 shadow", {w_o, status_o, bank_o}, 0);

      op(1, 0, 1, 21'h1A2B3, 8'h11, 8'h1F, 4'h3); idle();
      chk("R2 tos after push", tos_o, 21'h1A2B3);
      chk("R2 ptr after push", ptr_o, 1);
      chk("R9 shadow saved", {w_o, status_o, bank_o}, {8'h11, 8'h1F, 4'h3});

      op(1, 0, 0, 21'h0BEEF, 8'h99, 8'h88, 4'h7); idle();
      chk("R9 plain push keeps shadow", {w_o, status_o, bank_o}, {8'h11, 8'h1F, 4'h3});
      chk("R2 second tos", tos_o, 21'h0BEEF);

      op(0, 1, 1, 0, 0, 0, 0); idle();
      chk("R3 ptr after pop", ptr_o, 1);
      chk("R3 tos after pop", tos_o, 21'h1A2B3);

      op(1, 0, 1, 21'h12345, 8'h22, 8'h05, 4'hC); idle();
      chk("R10 shadow overwritten", {w_o, status_o, bank_o}, {8'h22, 8'h05, 4'hC});

      op(1, 1, 0, 21'h1FFFF, 0, 0, 0); idle();
      chk("R8 push wins ptr", ptr_o, 3);
      chk("R8 push wins tos", tos_o, 21'h1FFFF);

      op(0, 1, 0, 0, 0, 0, 0);
      op(0, 1, 0, 0, 0, 0, 0);
      op(0, 1, 0, 0, 0, 0, 0); idle();
      chk("R3 empty after pops", ptr_o, 0);
      chk("R6 no flag yet", unf_o, 0);

      op(0, 1, 1, 0, 0, 0, 0); idle();
      chk("R6 unf set", unf_o, 1);
      chk("R6 ptr stays 0", ptr_o, 0);
      chk("R6 tos zero", tos_o, 0);

      for (int i = 0; i < DEPTH; i++) op(1, 0, 0, 21'(32'h10000 + i * 32'h123), 0, 0, 0);
      idle();
      chk("R4 full ptr", ptr_o, DEPTH);
      chk("R4 no ovf at full", ovf_o, 0);
      chk("R7 unf sticky", unf_o, 1);

      op(1, 0, 0, 21'h0DEAD, 0, 0, 0); idle();
      chk("R5 ovf set", ovf_o, 1);
      chk("R5 ptr held", ptr_o, DEPTH);
      chk("R5 tos kept", tos_o, 21'(32'h10000 + (DEPTH - 1) * 32'h123));

      for (int i = 0; i < DEPTH; i++) op(0, 1, 0, 0, 0, 0, 0);
      idle();
      chk("R3 drained", ptr_o, 0);
      chk("R7 ovf sticky", ovf_o, 1);
      chk("R3 all pops seen", exp_tos_q.size(), 0);

      @(posedge clk); #1 rst_n = 1'b0;
      #1 chk("R1 flags cleared", {ovf_o, unf_o}, 0);
      chk("R1 shadow cleared", {w_o, status_o, bank_o}, 0);
      #(CLK_NS) rst_n = 1'b1;
      finish_run();
   end
endmodule